// File: doc/BRIEF.md
# Ethernet PHY LED Function Controller

This block drives the status LEDs of a tri-speed Ethernet PHY. Each LED has two byte-wide configuration registers. They choose which PHY condition lights it steadily, which makes it blink at the fast rate and which makes it blink at the slow rate. They also choose which traffic events briefly invert it. Two shared registers set the fast and slow blink rates and hold the complex-function selectors. Those selectors are only stored and read back here, because the scan and complex-blink sequencing belong to another block.

The inputs are the link state, a link speed code, five PHY state flags, three single-cycle event strobes and a prescaled time-base tick. From the tick, a free-running divider produces square waves at 16, 8, 4 and 2 Hz. All LEDs that share a rate blink in phase. Software writes registers through a plain address/data port and reads them back combinationally.

Top module: `phy_led_ctrl`

## Requirements
- R1: After reset the registers read as follows. Address 0 (rate register) reads 0x00C5 and address 1 (complex register) reads 0x0067. The per-LED registers are at 2+2k (high) and 3+2k (low). The high registers read 0x70, 0x20, 0x40, 0x40 and the low registers read 0x03, 0x00, 0x00, 0x20 for LEDs 0 to 3. All LEDs are off while every status input is low.
- R2: Read data bits 15:8 are always zero. Reserved bits never store a written one: bit 3 of the rate register, bits 7 and 3 of the complex register, and bit 3 of each low register. An address beyond the last register reads zero and ignores writes.
- R3: High register bits 7:4 hold the steady-on selector. Its codes are: 1 link at 10, 2 link at 100, 3 link at 10 or 100, 4 link at 1000, 5 link at 10 or 1000, 6 link at 100 or 1000, 7 link at any speed, 8 powered down, 9 EEE, 10 auto-negotiation, 11 analog self-test, 12 cable diagnostics. The speed input encodes 0 = 10, 1 = 100, 2 = 1000 and 3 = no valid speed. A matching selector lights the LED one clock after the input is sampled.
- R4: Priority runs as follows. A matching steady-on selector gives on. Otherwise a matching fast selector (high bits 3:0) gives the fast wave. Otherwise a matching slow selector (low bits 7:4) gives the slow wave. Otherwise the LED is off.
- R5: Rate register bits 7:6 choose the fast rate and bits 5:4 choose the slow rate. Code c gives a square wave whose half period is HALF_TICKS·2^(3−c) ticks, so codes 0 to 3 are 2, 4, 8 and 16 Hz. The wave advances only on ticks.
- R6: Selector codes 0, 13, 14 and 15 never match.
- R7: Low register bits 2:0 form an event mask: bit 0 transmit, bit 1 receive, bit 2 collision. A strobe on a selected event inverts the LED for PULSE_TICKS ticks, starting two clocks after the strobe. Unselected events have no effect.
- R8: A selected event that arrives inside an open pulse window restarts the full window.
- R9: LEDs blinking at the same rate code toggle on the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW (4) | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | AW (4) | Read address |
| rd_data_o | output | 16 | Combinational read data |
| link_up_i | input | 1 | Link is up |
| link_spd_i | input | 2 | Speed code: 0 = 10, 1 = 100, 2 = 1000, 3 = none |
| pwr_down_i | input | 1 | PHY powered down |
| eee_i | input | 1 | Energy-efficient mode active |
| aneg_i | input | 1 | Auto-negotiation running |
| abist_i | input | 1 | Analog self-test running |
| cdiag_i | input | 1 | Cable diagnostics running |
| tx_act_i | input | 1 | Transmit activity strobe |
| rx_act_i | input | 1 | Receive activity strobe |
| col_i | input | 1 | Collision strobe |
| tick_i | input | 1 | Time-base tick |
| led_o | output | NUM_LED | LED outputs, registered |

## Verification
A corrupted condition decode or a bad priority order shows on an LED one clock after the status inputs settle, so these checks sample that one cycle. A divider fault appears as a wrong toggle interval, or as two LEDs on the same rate falling out of step, within two half periods of the wave. A pulse counter that loads or counts wrongly shows as an LED that flips back too early or too late. The window edges are therefore checked to the exact tick.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;

   typedef struct packed {
      logic       link;
      logic [1:0] spd;
      logic       pdn;
      logic       eee;
      logic       aneg;
      logic       abist;
      logic       cdiag;
   } phy_stat_t;

   localparam int unsigned PH_W      = 4;
   localparam logic [7:0] RATE_RST   = 8'hC5;
   localparam logic [7:0] CPLX_RST   = 8'h67;
   localparam logic [7:0] RATE_MASK  = 8'hF7;
   localparam logic [7:0] CPLX_MASK  = 8'h77;
   localparam logic [7:0] HI_MASK    = 8'hFF;
   localparam logic [7:0] LO_MASK    = 8'hF7;

   function automatic logic [7:0] hi_rst(input int idx);
      case (idx)
         0:       return 8'h70;
         1:       return 8'h20;
         default: return 8'h40;
      endcase
   endfunction

   function automatic logic [7:0] lo_rst(input int idx);
      case (idx)
         0:       return 8'h03;
         3:       return 8'h20;
         default: return 8'h00;
      endcase
   endfunction

   // selectors below 8 are a speed bit set gated by link; 8..12 are flags
   function automatic logic cond_hit(input logic [3:0] sel, input phy_stat_t st);
      logic [2:0] spd_oh;
      logic       r;
      case (st.spd)
         2'd0:    spd_oh = 3'b001;
         2'd1:    spd_oh = 3'b010;
         2'd2:    spd_oh = 3'b100;
         default: spd_oh = 3'b000;
      endcase
      r = 1'b0;
      if (!sel[3]) begin
         r = st.link && (|(sel[2:0] & spd_oh));
      end else begin
         case (sel[2:0])
            3'd0:    r = st.pdn;
            3'd1:    r = st.eee;
            3'd2:    r = st.aneg;
            3'd3:    r = st.abist;
            3'd4:    r = st.cdiag;
            default: r = 1'b0;
         endcase
      end
      return r;
   endfunction

endpackage

// File: rtl/led_blink_tbase.sv
module led_blink_tbase
   import phy_led_pkg::*;
#(
   parameter int HALF_TICKS = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick_i,
   output logic [PH_W-1:0] ph_o
);

   generate
      if (HALF_TICKS < 1) begin : g_bad
         $error("HALF_TICKS must be at least 1");
      end

      if (HALF_TICKS == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      ph_o <= '0;
            else if (tick_i) ph_o <= ph_o + 1'b1;
         end
      end else begin : g_div
         localparam int CW = $clog2(HALF_TICKS);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt  <= '0;
               ph_o <= '0;
            end else if (tick_i) begin
               if (cnt == CW'(HALF_TICKS - 1)) begin
                  cnt  <= '0;
                  ph_o <= ph_o + 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/led_cfg_regs.sv
module led_cfg_regs
   import phy_led_pkg::*;
#(
   parameter int NUM_LED = 4,
   parameter int AW      = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en_i,
   input  logic [AW-1:0]              wr_addr_i,
   input  logic [7:0]                 wr_data_i,
   input  logic [AW-1:0]              rd_addr_i,
   output logic [15:0]                rd_data_o,
   output logic [1:0]                 fast_code_o,
   output logic [1:0]                 slow_code_o,
   output logic [NUM_LED-1:0][3:0]    con_sel_o,
   output logic [NUM_LED-1:0][3:0]    fst_sel_o,
   output logic [NUM_LED-1:0][3:0]    slw_sel_o,
   output logic [NUM_LED-1:0][2:0]    pmask_o
);

   logic [7:0] rate_q;
   logic [7:0] cplx_q;
   logic [7:0] hi_q [NUM_LED];
   logic [7:0] lo_q [NUM_LED];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_q <= RATE_RST;
         cplx_q <= CPLX_RST;
         for (int k = 0; k < NUM_LED; k++) begin
            hi_q[k] <= hi_rst(k);
            lo_q[k] <= lo_rst(k);
         end
      end else if (wr_en_i) begin
         if (wr_addr_i == AW'(0)) rate_q <= wr_data_i & RATE_MASK;
         if (wr_addr_i == AW'(1)) cplx_q <= wr_data_i & CPLX_MASK;
         for (int k = 0; k < NUM_LED; k++) begin
            if (wr_addr_i == AW'(2 + 2*k)) hi_q[k] <= wr_data_i & HI_MASK;
            if (wr_addr_i == AW'(3 + 2*k)) lo_q[k] <= wr_data_i & LO_MASK;
         end
      end
   end

   always_comb begin
      rd_data_o = '0;
      if (rd_addr_i == AW'(0)) rd_data_o[7:0] = rate_q;
      if (rd_addr_i == AW'(1)) rd_data_o[7:0] = cplx_q;
      for (int k = 0; k < NUM_LED; k++) begin
         if (rd_addr_i == AW'(2 + 2*k)) rd_data_o[7:0] = hi_q[k];
         if (rd_addr_i == AW'(3 + 2*k)) rd_data_o[7:0] = lo_q[k];
      end
   end

   assign fast_code_o = rate_q[7:6];
   assign slow_code_o = rate_q[5:4];

   generate
      for (genvar k = 0; k < NUM_LED; k++) begin : g_fld
         assign con_sel_o[k] = hi_q[k][7:4];
         assign fst_sel_o[k] = hi_q[k][3:0];
         assign slw_sel_o[k] = lo_q[k][7:4];
         assign pmask_o[k]   = lo_q[k][2:0];
      end
   endgenerate

endmodule

// File: rtl/led_chan.sv
module led_chan
   import phy_led_pkg::*;
#(
   parameter int PULSE_TICKS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  phy_stat_t  st_i,
   input  logic [2:0] ev_i,
   input  logic [3:0] con_sel_i,
   input  logic [3:0] fst_sel_i,
   input  logic [3:0] slw_sel_i,
   input  logic [2:0] pmask_i,
   input  logic       fast_w_i,
   input  logic       slow_w_i,
   output logic       led_o,
   output logic       pulse_act_o
);

   localparam int PCW = $clog2(PULSE_TICKS + 1);

   logic [PCW-1:0] pcnt;
   logic           hit;
   logic           base;

   assign hit = |(pmask_i & ev_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      pcnt <= '0;
      else if (hit)                    pcnt <= PCW'(PULSE_TICKS);
      else if (tick_i && pcnt != '0)   pcnt <= pcnt - 1'b1;
   end

   assign pulse_act_o = (pcnt != '0);

   always_comb begin
      if (cond_hit(con_sel_i, st_i))      base = 1'b1;
      else if (cond_hit(fst_sel_i, st_i)) base = fast_w_i;
      else if (cond_hit(slw_sel_i, st_i)) base = slow_w_i;
      else                                base = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) led_o <= 1'b0;
      else        led_o <= base ^ pulse_act_o;
   end

endmodule

// File: rtl/phy_led_ctrl.sv
module phy_led_ctrl
   import phy_led_pkg::*;
#(
   parameter  int NUM_LED     = 4,
   parameter  int HALF_TICKS  = 2,
   parameter  int PULSE_TICKS = 16,
   localparam int NREG        = 2 + 2*NUM_LED,
   localparam int AW          = $clog2(NREG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en_i,
   input  logic [AW-1:0]      wr_addr_i,
   input  logic [7:0]         wr_data_i,
   input  logic [AW-1:0]      rd_addr_i,
   output logic [15:0]        rd_data_o,
   input  logic               link_up_i,
   input  logic [1:0]         link_spd_i,
   input  logic               pwr_down_i,
   input  logic               eee_i,
   input  logic               aneg_i,
   input  logic               abist_i,
   input  logic               cdiag_i,
   input  logic               tx_act_i,
   input  logic               rx_act_i,
   input  logic               col_i,
   input  logic               tick_i,
   output logic [NUM_LED-1:0] led_o
);

   generate
      if (NUM_LED < 1 || NUM_LED > 4) begin : g_bad_n
         $error("NUM_LED must be 1 to 4");
      end
      if (PULSE_TICKS < 1) begin : g_bad_p
         $error("PULSE_TICKS must be at least 1");
      end
   endgenerate

   phy_stat_t              st;
   logic [2:0]             ev;
   logic [1:0]             fast_code, slow_code;
   logic [NUM_LED-1:0][3:0] con_sel, fst_sel, slw_sel;
   logic [NUM_LED-1:0][2:0] pmask;
   logic [PH_W-1:0]        ph;
   logic                   fast_w, slow_w;
   logic [NUM_LED-1:0]     pulse_act;

   assign st = '{link: link_up_i, spd: link_spd_i, pdn: pwr_down_i, eee: eee_i,
                 aneg: aneg_i, abist: abist_i, cdiag: cdiag_i};
   assign ev = {col_i, rx_act_i, tx_act_i};

   led_cfg_regs #(.NUM_LED(NUM_LED), .AW(AW)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en_i     (wr_en_i),
      .wr_addr_i   (wr_addr_i),
      .wr_data_i   (wr_data_i),
      .rd_addr_i   (rd_addr_i),
      .rd_data_o   (rd_data_o),
      .fast_code_o (fast_code),
      .slow_code_o (slow_code),
      .con_sel_o   (con_sel),
      .fst_sel_o   (fst_sel),
      .slw_sel_o   (slw_sel),
      .pmask_o     (pmask)
   );

   led_blink_tbase #(.HALF_TICKS(HALF_TICKS)) u_tbase (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .ph_o   (ph)
   );

   // code 3 taps the fastest phase bit, code 0 the slowest
   assign fast_w = ph[2'd3 - fast_code];
   assign slow_w = ph[2'd3 - slow_code];

   generate
      for (genvar k = 0; k < NUM_LED; k++) begin : g_led
         led_chan #(.PULSE_TICKS(PULSE_TICKS)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick_i      (tick_i),
            .st_i        (st),
            .ev_i        (ev),
            .con_sel_i   (con_sel[k]),
            .fst_sel_i   (fst_sel[k]),
            .slw_sel_i   (slw_sel[k]),
            .pmask_i     (pmask[k]),
            .fast_w_i    (fast_w),
            .slow_w_i    (slow_w),
            .led_o       (led_o[k]),
            .pulse_act_o (pulse_act[k])
         );
      end
   endgenerate

endmodule

// File: rtl/phy_led_ctrl_chk.sv
module phy_led_ctrl_chk #(
   parameter int NUM_LED = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    wr_en_i,
   input logic                    tick_i,
   input logic                    tx_act_i,
   input logic                    rx_act_i,
   input logic                    col_i,
   input logic                    link_up_i,
   input logic [1:0]              link_spd_i,
   input logic                    pwr_down_i,
   input logic                    eee_i,
   input logic                    aneg_i,
   input logic                    abist_i,
   input logic                    cdiag_i,
   input logic [15:0]             rd_data_o,
   input logic [NUM_LED-1:0]      led_o,
   input logic [3:0]              ph,
   input logic [NUM_LED-1:0]      pulse_act,
   input logic [NUM_LED-1:0][2:0] pmask
);

   logic       armed;
   logic       quiet;
   logic [7:0] stat;
   logic [2:0] ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assign quiet = !tick_i && !tx_act_i && !rx_act_i && !col_i && !wr_en_i;
   assign stat  = {link_up_i, link_spd_i, pwr_down_i, eee_i, aneg_i, abist_i, cdiag_i};
   assign ev    = {col_i, rx_act_i, tx_act_i};

   AST_RSV_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data_o[15:8] == 8'h00);  // R2

   AST_LED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(quiet) && $stable(stat) |=> $stable(led_o));  // R3

   AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(ph));  // R5

   generate
      for (genvar k = 0; k < NUM_LED; k++) begin : g_pl
         AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
            (|(pmask[k] & ev)) |=> pulse_act[k]);  // R7

         AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            pulse_act[k] && !tick_i |=> pulse_act[k]);  // R8
      end
   endgenerate

endmodule

bind phy_led_ctrl phy_led_ctrl_chk #(.NUM_LED(NUM_LED)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en_i    (wr_en_i),
   .tick_i     (tick_i),
   .tx_act_i   (tx_act_i),
   .rx_act_i   (rx_act_i),
   .col_i      (col_i),
   .link_up_i  (link_up_i),
   .link_spd_i (link_spd_i),
   .pwr_down_i (pwr_down_i),
   .eee_i      (eee_i),
   .aneg_i     (aneg_i),
   .abist_i    (abist_i),
   .cdiag_i    (cdiag_i),
   .rd_data_o  (rd_data_o),
   .led_o      (led_o),
   .ph         (ph),
   .pulse_act  (pulse_act),
   .pmask      (pmask)
);

// File: tb/tb_phy_led_ctrl.sv
module tb_phy_led_ctrl;

   localparam int NL  = 4;
   localparam int TPH = 2;
   localparam int PT  = 16;
   localparam int AW  = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [15:0]   rd_data;
   logic          link = 0, pdn = 0, eee = 0, aneg = 0, abist = 0, cdiag = 0;
   logic [1:0]    spd = 2'd3;
   logic          tx = 0, rx = 0, col = 0, tick = 0;
   logic [NL-1:0] led;

   always #5 clk = ~clk;

   phy_led_ctrl #(.NUM_LED(NL), .HALF_TICKS(TPH), .PULSE_TICKS(PT)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
      .link_up_i(link), .link_spd_i(spd), .pwr_down_i(pdn), .eee_i(eee),
      .aneg_i(aneg), .abist_i(abist), .cdiag_i(cdiag), .tx_act_i(tx),
      .rx_act_i(rx), .col_i(col), .tick_i(tick), .led_o(led)
   );

   // scoreboard
   typedef struct {
      string       req;
      logic [15:0] exp;
   } item_t;

   item_t       exp_q[$];
   logic [15:0] act_q[$];
   int          n_run  = 0;
   int          n_fail = 0;
   bit          ended  = 0;
   event        ev_new;

   function automatic void drain();
      while (act_q.size() > 0 && exp_q.size() > 0) begin
         item_t       it;
         logic [15:0] a;
         it = exp_q.pop_front();
         a  = act_q.pop_front();
         n_run++;
         if (a !== it.exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", it.req, a, it.exp);
         end
      end
   endfunction

   initial forever begin
      @(ev_new);
      drain();
   end

   task automatic expect_val(input string req, input logic [15:0] exp, input logic [15:0] act);
      exp_q.push_back('{req, exp});
      act_q.push_back(act);
      ->ev_new;
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         drain();
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1; wr_addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic rd_chk(input string req, input int a, input logic [15:0] exp);
      @(negedge clk);
      rd_addr = AW'(a);
      #1;
      expect_val(req, exp, rd_data);
   endtask

   task automatic ticks(input int n);
      repeat (n) begin
         @(negedge clk); tick = 1;
         @(negedge clk); tick = 0;
      end
   endtask

   task automatic pulse(input logic t, input logic r, input logic c);
      @(negedge clk); tx = t; rx = r; col = c;
      @(negedge clk); tx = 0; rx = 0; col = 0;
   endtask

   task automatic set_pat(input int p);
      link = 0; spd = 2'd3; pdn = 0; eee = 0; aneg = 0; abist = 0; cdiag = 0;
      case (p)
         0: begin link = 1; spd = 2'd0; end
         1: begin link = 1; spd = 2'd1; end
         2: begin link = 1; spd = 2'd2; end
         3: begin link = 1; spd = 2'd3; end
         4: begin link = 0; spd = 2'd1; end
         5: pdn   = 1;
         6: eee   = 1;
         7: aneg  = 1;
         8: abist = 1;
         default: cdiag = 1;
      endcase
   endtask

   // reference decode written from the selector table
   function automatic logic model_cond(input int sel);
      case (sel)
         1:  return link && spd == 2'd0;
         2:  return link && spd == 2'd1;
         3:  return link && (spd == 2'd0 || spd == 2'd1);
         4:  return link && spd == 2'd2;
         5:  return link && (spd == 2'd0 || spd == 2'd2);
         6:  return link && (spd == 2'd1 || spd == 2'd2);
         7:  return link && spd != 2'd3;
         8:  return pdn;
         9:  return eee;
         10: return aneg;
         11: return abist;
         12: return cdiag;
         default: return 1'b0;
      endcase
   endfunction

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [7:0] rst_vals [10];
      rst_vals = '{8'hC5, 8'h67, 8'h70, 8'h03, 8'h20, 8'h00, 8'h40, 8'h00, 8'h40, 8'h20};

      step(3);
      rst_n = 1;
      step(2);

      // R1 reset state
      expect_val("R1 leds off", 16'(0), 16'(led));
      for (int a = 0; a < 10; a++) rd_chk("R1 reset value", a, {8'h00, rst_vals[a]});

      // R2 reserved bits and out-of-range addresses
      wr(0, 8'hFF); rd_chk("R2 rate reg", 0, 16'h00F7);
      wr(1, 8'hFF); rd_chk("R2 complex reg", 1, 16'h0077);
      wr(3, 8'hFF); rd_chk("R2 low reg", 3, 16'h00F7);
      wr(12, 8'hFF);
      for (int a = 10; a < 16; a++) rd_chk("R2 unmapped", a, 16'h0000);
      wr(3, 8'h00);

      // R3 / R6 steady-on decode on LED0
      for (int sel = 0; sel < 16; sel++) begin
         wr(2, 8'(sel << 4));
         for (int p = 0; p < 10; p++) begin
            @(negedge clk); set_pat(p);
            @(negedge clk);
            expect_val(sel >= 13 ? "R6 unused selector" : "R3 steady decode",
                       16'(model_cond(sel)), 16'(led[0]));
         end
      end
      set_pat(3); link = 0;

      // R4 priority; 2 ticks -> phase 1: 16 Hz wave high, 2 Hz wave low
      wr(2, 8'h00);
      wr(0, 8'hC0);
      wr(6, 8'h89);
      wr(7, 8'hA0);
      ticks(2);
      @(negedge clk); pdn = 1; eee = 1; aneg = 1;
      @(negedge clk); expect_val("R4 steady wins", 16'(1), 16'(led[2]));
      @(negedge clk); pdn = 0;
      @(negedge clk); expect_val("R4 fast wave high", 16'(1), 16'(led[2]));
      @(negedge clk); eee = 0;
      @(negedge clk); expect_val("R4 slow wave low", 16'(0), 16'(led[2]));
      wr(0, 8'h30);
      step(1); expect_val("R4 slow 16 Hz high", 16'(1), 16'(led[2]));
      @(negedge clk); eee = 1;
      @(negedge clk); expect_val("R4 fast beats slow", 16'(0), 16'(led[2]));
      @(negedge clk); eee = 0; aneg = 0;
      @(negedge clk); expect_val("R4 none off", 16'(0), 16'(led[2]));

      // R5 / R9 periods, LED0 and LED2 on the fast rate
      wr(2, 8'h09); wr(3, 8'h00);
      wr(6, 8'h09); wr(7, 8'h00);
      @(negedge clk); eee = 1;
      for (int c = 0; c < 5; c++) begin
         int half, last, mism;
         logic prev;
         if (c < 4) begin
            wr(0, 8'(c << 6));
            half = TPH << (3 - c);
         end else begin
            wr(6, 8'h00); wr(7, 8'h90);
            wr(0, 8'h10);
            half = TPH << 2;
         end
         step(2);
         @(negedge clk); tick = 1;
         prev = led[2]; last = -1; mism = 0;
         for (int i = 0; i < 72; i++) begin
            @(negedge clk);
            if (c < 4 && led[0] !== led[2]) mism++;
            if (led[2] !== prev) begin
               if (last >= 0) expect_val("R5 half period", 16'(half), 16'(i - last));
               last = i;
               prev = led[2];
            end
         end
         tick = 0;
         if (c < 4) expect_val("R9 in phase", 16'(0), 16'(mism));
      end
      @(negedge clk); eee = 0;
      wr(2, 8'h00); wr(7, 8'h00);

      // R7 pulse window on LED1 (transmit selected)
      wr(4, 8'h00); wr(5, 8'h01);
      step(1); expect_val("R7 idle off", 16'(0), 16'(led[1]));
      pulse(1, 0, 0);
      step(1); expect_val("R7 pulse on", 16'(1), 16'(led[1]));
      ticks(PT - 1); step(1); expect_val("R7 window last tick", 16'(1), 16'(led[1]));
      ticks(1); step(1); expect_val("R7 window closed", 16'(0), 16'(led[1]));

      // R8 restart
      pulse(1, 0, 0);
      ticks(10);
      pulse(1, 0, 0);
      ticks(PT - 1); step(1); expect_val("R8 restarted window", 16'(1), 16'(led[1]));
      ticks(1); step(1); expect_val("R8 restarted close", 16'(0), 16'(led[1]));

      // R7 inversion of a lit LED, masking
      wr(4, 8'h20); wr(5, 8'h02);
      @(negedge clk); link = 1; spd = 2'd1;
      @(negedge clk); expect_val("R7 steady on", 16'(1), 16'(led[1]));
      pulse(0, 1, 0);
      step(1); expect_val("R7 inverted", 16'(0), 16'(led[1]));
      ticks(PT); step(1); expect_val("R7 restored", 16'(1), 16'(led[1]));
      pulse(1, 0, 1);
      step(1); expect_val("R7 masked events", 16'(1), 16'(led[1]));
      step(1); expect_val("R7 masked events later", 16'(1), 16'(led[1]));
      wr(5, 8'h08);
      rd_chk("R2 mask reserved bit", 5, 16'h0000);
      pulse(1, 1, 1);
      step(1); expect_val("R7 reserved mask bit", 16'(1), 16'(led[1]));

      step(2);
      finish_run();
   end

endmodule